// File: doc/BRIEF.md
# Interrupt Translation Map Command Processor

This block carries out one mapping command of an interrupt translation service. Once a command is handed over through a valid/ready start handshake, it reads three consecutive 64-bit doublewords of the command from memory. It pulls the device ID, the event ID, the physical interrupt ID and the collection ID out of those doublewords. It then asks an external lookup port for the device table entry that belongs to the device ID. Last, it checks the entry's valid flag, the event range and the physical ID range. A command that passes every check leaves as a single translation-table write strobe. A command that fails leaves as a single error pulse with a reason code.

A per-command control input selects the variant of the command that has no physical-ID field. In that variant the event ID also serves as the physical interrupt ID, and the physical-ID range check is skipped. The block works on one command at a time. A single state machine runs through these states in order: IDLE, FETCH1, FETCH2, FETCH3, LOOKUP, CHECK, DONE. The transitions are as follows:
- IDLE goes to FETCH1 when a start is accepted.
- Each FETCHn moves to the next fetch state on a good read response. FETCH3 moves to LOOKUP on its good response.
- Any FETCHn jumps to DONE on an error response.
- LOOKUP goes to CHECK on a good response and to DONE on a lookup error.
- CHECK always goes to DONE.
- DONE always returns to IDLE.

Top module: `itmap_cmd_proc`

## Requirements
- R1: After reset the block is in IDLE. start_ready is high, and rd_req, dte_req, wr_valid and err_valid are low. start_ready is high only in IDLE, so no second command is accepted before the result of the current one.
- R2: The three command reads go out in order at cmd_base+cmd_offset, then +8, then +16. Each read holds rd_req and a stable rd_addr until the cycle in which rd_ack is high.
- R3: The fields sit at fixed positions. The device ID is bits 63:32 of doubleword 0. The event ID is bits 31:0 of doubleword 1. The physical ID is bits 63:32 of doubleword 1. The collection ID is bits 15:0 of doubleword 2.
- R4: A read response with rd_err high ends the command in the next cycle with err_code 1. No further read, no lookup and no write follow.
- R5: When use_event_as_pid is high at the accepted start, the physical ID written equals the event ID, and the physical-ID range check (R9) is not applied.
- R6: After the third good read, dte_req rises with dte_devid equal to the device ID. A lookup response with dte_err high ends the command in the next cycle with err_code 2 and no write.
- R7: A device table entry with bit 0 clear is rejected with err_code 3.
- R8: The event count is 2^(size+1), where size is bits 5:1 of the device table entry. An event ID at or above the count is rejected with err_code 4.
- R9: A physical ID of 1023 is always accepted. Any other value is rejected with err_code 5 if it is below 8192. It is also rejected with err_code 5 if id_bits is below 32 and the value is at or above 2^id_bits.
- R10: Rejection reasons are checked in a fixed priority: code 3 first, then code 4, then code 5.
- R11: A good lookup response leads, two cycles later, to exactly one of wr_valid or err_valid. The pulse lasts one cycle. A write carries the device ID, event ID, physical ID and collection ID, with wr_entry_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_valid | input | 1 | Command start request |
| start_ready | output | 1 | Block is idle and can accept a command |
| cmd_base | input | ADDR_W | Command queue base address |
| cmd_offset | input | OFF_W | Byte offset of the command in the queue |
| use_event_as_pid | input | 1 | Variant select: physical ID taken from event ID |
| id_bits | input | 6 | Configured interrupt ID width (14 to 32), static |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 64 | Read response data |
| rd_err | input | 1 | Read response carries an error |
| dte_req | output | 1 | Device table lookup request |
| dte_devid | output | 32 | Device ID to look up |
| dte_ack | input | 1 | Lookup response valid |
| dte_data | input | 64 | Device table entry |
| dte_err | input | 1 | Lookup response carries an error |
| wr_valid | output | 1 | Translation entry write strobe |
| wr_devid | output | 32 | Device ID of the entry |
| wr_eventid | output | 32 | Event ID of the entry |
| wr_pintid | output | 32 | Physical interrupt ID of the entry |
| wr_icid | output | ICID_W | Collection ID of the entry |
| wr_entry_valid | output | 1 | Valid flag of the written entry |
| err_valid | output | 1 | Command rejected pulse |
| err_code | output | 3 | Reason: 1 read, 2 lookup, 3 invalid entry, 4 event range, 5 physical ID range |

## Verification
Some properties are checked by assertions on every cycle:
- read requests hold steady until acknowledged;
- the address steps by eight between fetches;
- an error response is followed at once by an error pulse with no write or lookup;
- every write is a single-cycle strobe marked valid;
- outside the variant, every written physical ID is 1023 or at least 8192.

Other properties need the bench's scenarios to show them:
- the exact field extraction;
- the event-count arithmetic for each size value;
- the id_bits upper bound;
- the rejection priority;
- the variant's substitution of the event ID.

The bench exercises these with directed boundary values and with random commands under random response stalls.

// File: rtl/itmap_pkg.sv
package itmap_pkg;

    localparam int DW_W    = 64;
    localparam int ID_W    = 32;
    localparam int CODE_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_LOOKUP,
        ST_CHECK,
        ST_DONE
    } map_state_e;

    typedef enum logic [CODE_W-1:0] {
        RSN_NONE      = 3'd0,
        RSN_READ      = 3'd1,
        RSN_LOOKUP    = 3'd2,
        RSN_DTE_INVAL = 3'd3,
        RSN_EVENT     = 3'd4,
        RSN_PINTID    = 3'd5
    } reject_e;

endpackage

// File: rtl/itmap_field_capture.sv
module itmap_field_capture
    import itmap_pkg::*;
#(
    parameter int ICID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cap_en,
    input  logic [DW_W-1:0]   dword,
    output logic [ID_W-1:0]   devid,
    output logic [ID_W-1:0]   eventid,
    output logic [ID_W-1:0]   pid_raw,
    output logic [ICID_W-1:0] icid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            devid   <= '0;
            eventid <= '0;
            pid_raw <= '0;
            icid    <= '0;
        end else begin
            if (cap_en[0]) devid <= dword[63:32];
            if (cap_en[1]) begin
                eventid <= dword[31:0];
                pid_raw <= dword[63:32];
            end
            if (cap_en[2]) icid <= dword[ICID_W-1:0];
        end
    end

endmodule

// File: rtl/itmap_limit_check.sv
module itmap_limit_check
    import itmap_pkg::*;
#(
    parameter int LPI_BASE   = 8192,
    parameter int SPECIAL_ID = 1023
) (
    input  logic [DW_W-1:0] dte,
    input  logic [ID_W-1:0] eventid,
    input  logic [ID_W-1:0] pintid,
    input  logic [5:0]      id_bits,
    input  logic            skip_pid,
    output reject_e         reason
);

    logic [5:0]    ev_shift;
    logic [ID_W:0] ev_rest;
    logic [ID_W:0] pid_rest;
    logic          ev_ok;
    logic          pid_ok;

    always_comb begin
        ev_shift = {1'b0, dte[5:1]} + 6'd1;
        ev_rest  = {1'b0, eventid} >> ev_shift;
        ev_ok    = (ev_rest == '0);
        pid_rest = {1'b0, pintid} >> id_bits;
        pid_ok   = (pintid == ID_W'(SPECIAL_ID)) ||
                   ((pintid >= ID_W'(LPI_BASE)) && (pid_rest == '0));
        if (!dte[0])                reason = RSN_DTE_INVAL;
        else if (!ev_ok)            reason = RSN_EVENT;
        else if (!skip_pid && !pid_ok) reason = RSN_PINTID;
        else                        reason = RSN_NONE;
    end

endmodule

// File: rtl/itmap_cmd_proc.sv
module itmap_cmd_proc
    import itmap_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int OFF_W      = 20,
    parameter int ICID_W     = 16,
    parameter int LPI_BASE   = 8192,
    parameter int SPECIAL_ID = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [OFF_W-1:0]  cmd_offset,
    input  logic              use_event_as_pid,
    input  logic [5:0]        id_bits,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [63:0]       rd_data,
    input  logic              rd_err,
    output logic              dte_req,
    output logic [31:0]       dte_devid,
    input  logic              dte_ack,
    input  logic [63:0]       dte_data,
    input  logic              dte_err,
    output logic              wr_valid,
    output logic [31:0]       wr_devid,
    output logic [31:0]       wr_eventid,
    output logic [31:0]       wr_pintid,
    output logic [ICID_W-1:0] wr_icid,
    output logic              wr_entry_valid,
    output logic              err_valid,
    output logic [2:0]        err_code
);

    localparam int DW_BYTES = DW_W / 8;

    map_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cmd_addr_q;
    logic              var_q;
    logic [DW_W-1:0]   dte_q;
    reject_e           res_q;
    reject_e           chk_reason;
    logic [2:0]        cap_en;
    logic [1:0]        fetch_idx;
    logic [ID_W-1:0]   f_devid, f_eventid, f_pid_raw;
    logic [ICID_W-1:0] f_icid;
    logic [ID_W-1:0]   eff_pid;
    logic              rd_good;

    assign rd_good = rd_req && rd_ack && !rd_err;
    assign eff_pid = var_q ? f_eventid : f_pid_raw;

    itmap_field_capture #(.ICID_W(ICID_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .dword   (rd_data),
        .devid   (f_devid),
        .eventid (f_eventid),
        .pid_raw (f_pid_raw),
        .icid    (f_icid)
    );

    itmap_limit_check #(.LPI_BASE(LPI_BASE), .SPECIAL_ID(SPECIAL_ID)) u_limits (
        .dte      (dte_q),
        .eventid  (f_eventid),
        .pintid   (eff_pid),
        .id_bits  (id_bits),
        .skip_pid (var_q),
        .reason   (chk_reason)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_valid)           state_d = ST_FETCH1;
            ST_FETCH1: if (rd_ack) state_d = rd_err ? ST_DONE : ST_FETCH2;
            ST_FETCH2: if (rd_ack) state_d = rd_err ? ST_DONE : ST_FETCH3;
            ST_FETCH3: if (rd_ack) state_d = rd_err ? ST_DONE : ST_LOOKUP;
            ST_LOOKUP: if (dte_ack) state_d = dte_err ? ST_DONE : ST_CHECK;
            ST_CHECK:                             state_d = ST_DONE;
            ST_DONE:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr_q <= '0;
            var_q      <= 1'b0;
            dte_q      <= '0;
            res_q      <= RSN_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_valid) begin
                    cmd_addr_q <= cmd_base + ADDR_W'(cmd_offset);
                    var_q      <= use_event_as_pid;
                    res_q      <= RSN_NONE;
                end
                ST_FETCH1, ST_FETCH2, ST_FETCH3:
                    if (rd_ack && rd_err) res_q <= RSN_READ;
                ST_LOOKUP: if (dte_ack) begin
                    if (dte_err) res_q <= RSN_LOOKUP;
                    else         dte_q <= dte_data;
                end
                ST_CHECK: res_q <= chk_reason;
                ST_DONE:  ;
                default:  ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        start_ready    = (state_q == ST_IDLE);
        fetch_idx      = 2'd0;
        rd_req         = 1'b0;
        cap_en         = 3'b000;
        dte_req        = 1'b0;
        wr_valid       = 1'b0;
        err_valid      = 1'b0;
        unique case (state_q)
            ST_FETCH1: begin rd_req = 1'b1; fetch_idx = 2'd0; cap_en[0] = rd_good; end
            ST_FETCH2: begin rd_req = 1'b1; fetch_idx = 2'd1; cap_en[1] = rd_good; end
            ST_FETCH3: begin rd_req = 1'b1; fetch_idx = 2'd2; cap_en[2] = rd_good; end
            ST_LOOKUP: dte_req = 1'b1;
            ST_DONE: begin
                wr_valid  = (res_q == RSN_NONE);
                err_valid = (res_q != RSN_NONE);
            end
            default: ;
        endcase
        rd_addr        = cmd_addr_q + ADDR_W'(fetch_idx) * ADDR_W'(DW_BYTES);
        dte_devid      = f_devid;
        wr_devid       = f_devid;
        wr_eventid     = f_eventid;
        wr_pintid      = eff_pid;
        wr_icid        = f_icid;
        wr_entry_valid = wr_valid;
        err_code       = res_q;
    end

    // Assertions
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_good && state_q != ST_FETCH3) |=>
            (rd_req && rd_addr == $past(rd_addr) + ADDR_W'(DW_BYTES)));

    a_r4_read_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=>
            (err_valid && err_code == 3'd1 && !wr_valid && !dte_req && !rd_req));

    a_r6_lookup_err: assert property (@(posedge clk) disable iff (!rst_n)
        (dte_req && dte_ack && dte_err) |=> (err_valid && err_code == 3'd2 && !wr_valid));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || err_valid) |=> !(wr_valid || err_valid));

    a_r11_entry_marked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_entry_valid && !err_valid));

    a_r9_pid_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !var_q) |->
            (wr_pintid == 32'(SPECIAL_ID) || wr_pintid >= 32'(LPI_BASE)));

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || dte_req) |-> !start_ready);

endmodule

// File: tb/itmap_cmd_proc_tb.sv
module itmap_cmd_proc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 48;
    localparam int OFF_W  = 20;
    localparam int ICID_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic              start_ready;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [OFF_W-1:0]  cmd_offset = '0;
    logic              use_event_as_pid = 1'b0;
    logic [5:0]        id_bits = 6'd16;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [63:0]       rd_data = '0;
    logic              rd_err = 1'b0;
    logic              dte_req;
    logic [31:0]       dte_devid;
    logic              dte_ack = 1'b0;
    logic [63:0]       dte_data = '0;
    logic              dte_err = 1'b0;
    logic              wr_valid;
    logic [31:0]       wr_devid, wr_eventid, wr_pintid;
    logic [ICID_W-1:0] wr_icid;
    logic              wr_entry_valid;
    logic              err_valid;
    logic [2:0]        err_code;

    int n_checks = 0;
    int n_errors = 0;

    logic [63:0] cur_dw [3];
    logic [63:0] cur_dte;
    int          cur_rd_err_idx;
    bit          cur_dte_err;
    logic [ADDR_W-1:0] cur_addr0;
    int          rd_cnt;
    int          dte_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    itmap_cmd_proc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ICID_W(ICID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .cmd_base(cmd_base), .cmd_offset(cmd_offset),
        .use_event_as_pid(use_event_as_pid), .id_bits(id_bits),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_err(rd_err),
        .dte_req(dte_req), .dte_devid(dte_devid), .dte_ack(dte_ack),
        .dte_data(dte_data), .dte_err(dte_err),
        .wr_valid(wr_valid), .wr_devid(wr_devid), .wr_eventid(wr_eventid),
        .wr_pintid(wr_pintid), .wr_icid(wr_icid), .wr_entry_valid(wr_entry_valid),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory responder with random stalls (R2, R3, R4)
    always @(negedge clk) begin
        if (rd_req && ($urandom % 3 != 0)) begin
            chk(rd_addr == cur_addr0 + ADDR_W'(8 * rd_cnt), "R2 read address",
                longint'(rd_addr), longint'(cur_addr0 + ADDR_W'(8 * rd_cnt)));
            rd_ack  <= 1'b1;
            rd_data <= (rd_cnt < 3) ? cur_dw[rd_cnt] : 64'hDEAD;
            rd_err  <= (rd_cnt == cur_rd_err_idx);
            rd_cnt  <= rd_cnt + 1;
        end else begin
            rd_ack <= 1'b0;
            rd_err <= 1'b0;
        end
    end

    // Device table responder (R6)
    always @(negedge clk) begin
        if (dte_req && ($urandom % 2 == 0)) begin
            chk(dte_devid == cur_dw[0][63:32], "R6 lookup device ID",
                longint'(dte_devid), longint'(cur_dw[0][63:32]));
            dte_ack  <= 1'b1;
            dte_data <= cur_dte;
            dte_err  <= cur_dte_err;
            dte_cnt  <= dte_cnt + 1;
        end else begin
            dte_ack <= 1'b0;
            dte_err <= 1'b0;
        end
    end

    function automatic int exp_code(input logic [63:0] dte, input logic [31:0] eid,
                                    input logic [31:0] pid, input bit var_, input int idb);
        if (!dte[0]) return 3;
        if (64'(eid) >= (64'd1 << (int'(dte[5:1]) + 1))) return 4;
        if (!var_ && pid != 32'd1023) begin
            if (pid < 32'd8192) return 5;
            if (idb < 32 && 64'(pid) >= (64'd1 << idb)) return 5;
        end
        return 0;
    endfunction

    task automatic run_cmd(input logic [31:0] devid, input logic [31:0] eid,
                           input logic [31:0] pid, input logic [15:0] icid,
                           input logic [63:0] dte, input bit var_, input int idb,
                           input int rd_err_idx, input bit lk_err, input string tag);
        int  exp;
        bit  seen;
        @(negedge clk);
        id_bits          = 6'(idb);
        cmd_base         = ADDR_W'({$urandom, $urandom}) & ~ADDR_W'(7);
        cmd_offset       = OFF_W'($urandom) & ~OFF_W'(7);
        cur_addr0        = cmd_base + ADDR_W'(cmd_offset);
        cur_dw[0]        = {devid, $urandom};
        cur_dw[1]        = {pid, eid};
        cur_dw[2]        = {$urandom, 16'($urandom), icid};
        cur_dte          = dte;
        cur_rd_err_idx   = rd_err_idx;
        cur_dte_err      = lk_err;
        rd_cnt           = 0;
        dte_cnt          = 0;
        use_event_as_pid = var_;
        chk(start_ready == 1'b1, {"R1 ready when idle ", tag}, start_ready, 1);
        start_valid = 1'b1;
        @(negedge clk);
        start_valid      = 1'b0;
        use_event_as_pid = ~var_;
        chk(start_ready == 1'b0, {"R1 not ready when busy ", tag}, start_ready, 0);
        if (rd_err_idx >= 0)  exp = 1;
        else if (lk_err)      exp = 2;
        else                  exp = exp_code(dte, eid, pid, var_, idb);
        seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            if (wr_valid || err_valid) seen = 1;
            else @(negedge clk);
        end
        chk(seen, {"R11 result arrives ", tag}, seen, 1);
        if (seen) begin
            if (exp == 0) begin
                chk(wr_valid && !err_valid, {"R11 write strobe ", tag}, wr_valid, 1);
                chk(wr_devid == devid, {"R3 devid ", tag}, wr_devid, devid);
                chk(wr_eventid == eid, {"R3 eventid ", tag}, wr_eventid, eid);
                chk(wr_pintid == (var_ ? eid : pid), {"R5 pintid ", tag},
                    wr_pintid, var_ ? eid : pid);
                chk(wr_icid == icid, {"R3 icid ", tag}, wr_icid, icid);
                chk(wr_entry_valid, {"R11 entry valid ", tag}, wr_entry_valid, 1);
            end else begin
                chk(err_valid && !wr_valid, {"R10 error pulse ", tag}, wr_valid, 0);
                chk(int'(err_code) == exp, {"R10 error code ", tag}, err_code, exp);
            end
            if (rd_err_idx >= 0) begin
                chk(rd_cnt == rd_err_idx + 1, {"R4 no read after error ", tag},
                    rd_cnt, rd_err_idx + 1);
                chk(dte_cnt == 0, {"R4 no lookup after error ", tag}, dte_cnt, 0);
            end
            @(negedge clk);
            chk(!wr_valid && !err_valid, {"R11 single pulse ", tag}, wr_valid | err_valid, 0);
            chk(start_ready, {"R1 back to idle ", tag}, start_ready, 1);
        end
        use_event_as_pid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    localparam logic [63:0] DTE_OK = 64'h1 | (64'd7 << 1);  // 256 events

    initial begin
        void'($urandom(32'd1234));
        cur_rd_err_idx = -1;
        cur_dte_err = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(start_ready && !rd_req && !dte_req && !wr_valid && !err_valid,
            "R1 reset state", {start_ready, rd_req, dte_req, wr_valid, err_valid}, 5'b10000);
        rst_n = 1'b1;
        // R3 plain success
        run_cmd(32'h1234_5678, 32'd5, 32'd9000, 16'hBEEF, DTE_OK, 0, 16, -1, 0, "R3 basic");
        // R5 variant: pid field ignored, eid small
        run_cmd(32'h77, 32'd12, 32'd3, 16'h0042, DTE_OK, 1, 16, -1, 0, "R5 variant");
        // R9 boundaries
        run_cmd(32'h1, 32'd0, 32'd1023, 16'h1, DTE_OK, 0, 14, -1, 0, "R9 special 1023");
        run_cmd(32'h1, 32'd0, 32'd8191, 16'h1, DTE_OK, 0, 14, -1, 0, "R9 8191 below range");
        run_cmd(32'h1, 32'd0, 32'd8192, 16'h1, DTE_OK, 0, 14, -1, 0, "R9 8192 ok");
        run_cmd(32'h1, 32'd0, 32'd16383, 16'h1, DTE_OK, 0, 14, -1, 0, "R9 top of 14 bits");
        run_cmd(32'h1, 32'd0, 32'd16384, 16'h1, DTE_OK, 0, 14, -1, 0, "R9 above 14 bits");
        run_cmd(32'h1, 32'd0, 32'hFFFF_FFFF, 16'h1, DTE_OK, 0, 32, -1, 0, "R9 32 bits max");
        // R8 event limits
        run_cmd(32'h2, 32'd255, 32'd9000, 16'h2, DTE_OK, 0, 16, -1, 0, "R8 last event");
        run_cmd(32'h2, 32'd256, 32'd9000, 16'h2, DTE_OK, 0, 16, -1, 0, "R8 event over");
        run_cmd(32'h2, 32'hFFFF_FFFF, 32'd9000, 16'h2, 64'h1 | (64'd31 << 1), 0, 16, -1, 0,
                "R8 size 31");
        run_cmd(32'h2, 32'd2, 32'd9000, 16'h2, 64'h1, 0, 16, -1, 0, "R8 size 0");
        // R7 invalid entry, R10 priority
        run_cmd(32'h3, 32'd1, 32'd9000, 16'h3, DTE_OK & ~64'h1, 0, 16, -1, 0, "R7 invalid");
        run_cmd(32'h3, 32'd999, 32'd5, 16'h3, DTE_OK & ~64'h1, 0, 16, -1, 0, "R10 invalid first");
        run_cmd(32'h3, 32'd999, 32'd5, 16'h3, DTE_OK, 0, 16, -1, 0, "R10 event before pid");
        // R4 read errors, R6 lookup error
        for (int k = 0; k < 3; k++)
            run_cmd(32'h4, 32'd1, 32'd9000, 16'h4, DTE_OK, 0, 16, k, 0, "R4 read error");
        run_cmd(32'h5, 32'd1, 32'd9000, 16'h5, DTE_OK, 0, 16, -1, 1, "R6 lookup error");
        // Random commands
        for (int n = 0; n < 60; n++) begin
            logic [31:0] pid;
            logic [63:0] dte;
            logic [31:0] eid;
            int sel = $urandom % 4;
            pid = (sel == 0) ? 32'd1023 : (sel == 1) ? 32'($urandom % 8192) :
                  (sel == 2) ? 32'd8192 + 32'($urandom % 65536) : $urandom;
            dte = {$urandom, $urandom};
            dte[0] = ($urandom % 5 != 0);
            dte[5:1] = 5'($urandom % 12);
            eid = ($urandom % 2 == 0) ? 32'($urandom % 4096) : $urandom;
            run_cmd($urandom, eid, pid, 16'($urandom), dte, ($urandom % 4 == 0),
                    14 + int'($urandom % 19), -1, 0, "R8 R9 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule